// File: doc/BRIEF.md
# Clash-Minimizing Test Vector Sequencer

This block holds a set of scan test pairs, each pair being a stimulus vector and the response expected after capture. When started, it streams out the indices of the stored pairs in an order that reduces polarity clashes. A clash happens when the bit that enters the chain first for the next vector differs from the bit that leaves the chain last for the previous response. Every clash ripples through each cell of the chain. The transitions it adds therefore scale with the clash count times the chain length.

Only two bits of each pair matter for the ordering. These are bit 0 of the vector and bit W-1 of the response, and together they form a two-bit group code. The block walks the groups under a fixed picking policy, with one index per cycle and bubble cycles between groups. It reports two clash counts: one for the plain ascending-index order and one for the order it produced. Driving the scan chain itself is left to the consumer of the index stream.

Top module: `scan_order_seq`

## Requirements
- R1: The group code of a pair is {vector bit 0, response bit W-1}. All pairs with code 00 are emitted first, in ascending index order.
- R2: Next comes exactly one pair of code 01, the lowest index of that group. This step is skipped without error when the group is empty.
- R3: After that step, every pair of code 11 is emitted in ascending index order.
- R4: The remaining pairs of codes 10 and 01 are then emitted alternately, starting with code 10. Each group is taken in ascending index order.
- R5: When one of the two alternating groups runs out, the remaining pairs of the other group are emitted consecutively.
- R6: Every stored index appears exactly once per run. `seq_last` is high on the final index only. With nothing stored, a run emits nothing and ends.
- R7: `clash_orig` equals the number of adjacent stored pairs, taken in ascending index order, where the response bit W-1 of the earlier pair differs from the vector bit 0 of the later pair.
- R8: `clash_new` counts the same relation over the emitted order. Nothing is counted for the first emitted pair. Both counts hold their values until the next accepted start.
- R9: While `busy` is high, loads and start pulses are ignored.
- R10: After reset, nothing is stored, `busy` and `seq_valid` are low, and both counts are zero.
- R11: A load when idle to an index below NUM_PAIRS stores that pair. Loading an index again overwrites the earlier pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Store a pair this cycle |
| ld_idx | input | IDX_W | Slot index of the pair |
| ld_vec | input | VEC_W | Stimulus vector |
| ld_rsp | input | VEC_W | Expected response |
| start | input | 1 | Pulse to begin a sequencing run |
| seq_valid | output | 1 | `seq_idx` carries an emitted index |
| seq_idx | output | IDX_W | Emitted pair index |
| seq_last | output | 1 | Final index of the run |
| busy | output | 1 | Run in progress |
| clash_orig | output | CNT_W | Clash count in ascending index order |
| clash_new | output | CNT_W | Clash count in emitted order |

## Verification
The bench first runs the worked seven-pair set, where three original clashes fall to none. It then runs sets drawn entirely from one group, sets that lack group 01 or group 10, and sets with uneven 10/01 populations. These separate the single-pick step, the alternation start and the drain path from each other. An empty store and a partly filled store with gaps in the indices show how stored-slot tracking interacts with the last flag. Loads and start pulses issued mid-run, followed by a rerun on the same data, show that busy-time stimulus leaves both the stored pairs and the stream untouched.

// File: rtl/sqo_pkg.sv
package sqo_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_EMIT00,
        ST_EMIT01_ONE,
        ST_EMIT11,
        ST_ALT10,
        ST_ALT01,
        ST_DRAIN,
        ST_DONE
    } seq_state_e;

    localparam logic [1:0] GRP_00 = 2'b00;
    localparam logic [1:0] GRP_01 = 2'b01;
    localparam logic [1:0] GRP_10 = 2'b10;
    localparam logic [1:0] GRP_11 = 2'b11;

endpackage

// File: rtl/sqo_pair_store.sv
module sqo_pair_store #(
    parameter int N  = 8,
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_req,
    input  logic                lock,
    input  logic [IW-1:0]       wr_idx,
    input  logic [W-1:0]        wr_vec,
    input  logic [W-1:0]        wr_rsp,
    output logic [N-1:0]        ent_valid,
    output logic [N-1:0][1:0]   ent_code
);

    typedef struct packed {
        logic [N-1:0]      valid;
        logic [N-1:0][1:0] code;
    } store_regs_t;

    store_regs_t r_q, r_d;
    logic        wr_ok;

    assign wr_ok = wr_req && !lock && (int'(wr_idx) < N);

    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            r_d.valid[wr_idx] = 1'b1;
            r_d.code[wr_idx]  = {wr_vec[0], wr_rsp[W-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ent_valid = r_q.valid;
    assign ent_code  = r_q.code;

    // R11: an accepted write lands in its slot with the derived group code
    p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> ent_valid[$past(wr_idx)] &&
                  ent_code[$past(wr_idx)] == {$past(wr_vec[0]), $past(wr_rsp[W-1])});

    // R9: a write during a run leaves the store untouched
    p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && lock) |=> ($stable(ent_valid) && $stable(ent_code)));

endmodule

// File: rtl/sqo_low_pick.sv
module sqo_low_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/scan_order_seq.sv
module scan_order_seq
    import sqo_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    parameter int VEC_W     = 8,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    localparam int CNT_W    = $clog2(NUM_PAIRS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [VEC_W-1:0] ld_vec,
    input  logic [VEC_W-1:0] ld_rsp,
    input  logic             start,
    output logic             seq_valid,
    output logic [IDX_W-1:0] seq_idx,
    output logic             seq_last,
    output logic             busy,
    output logic [CNT_W-1:0] clash_orig,
    output logic [CNT_W-1:0] clash_new
);

    localparam int NGRP = 4;

    typedef struct packed {
        seq_state_e           st;
        logic [IDX_W-1:0]     scan;
        logic [NUM_PAIRS-1:0] pend;
        logic [CNT_W-1:0]     total;
        logic [CNT_W-1:0]     emitted;
        logic [CNT_W-1:0]     c_orig;
        logic [CNT_W-1:0]     c_new;
        logic                 have_prev;
        logic                 prev_msb;
        logic [1:0]           drain_grp;
        logic                 ov;
        logic [IDX_W-1:0]     oidx;
        logic                 olast;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [NUM_PAIRS-1:0]         ent_valid;
    logic [NUM_PAIRS-1:0][1:0]    ent_code;
    logic [NGRP-1:0][NUM_PAIRS-1:0] grp_req;
    logic [NGRP-1:0]              grp_found;
    logic [NGRP-1:0][IDX_W-1:0]   grp_idx;
    logic                         busy_w;
    logic                         emit;
    logic [1:0]                   emit_grp;
    logic [IDX_W-1:0]             sel_idx;

    assign busy_w = (r_q.st != ST_IDLE && r_q.st != ST_DONE) || r_q.ov;

    sqo_pair_store #(.N(NUM_PAIRS), .W(VEC_W), .IW(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (ld_en),
        .lock      (busy_w),
        .wr_idx    (ld_idx),
        .wr_vec    (ld_vec),
        .wr_rsp    (ld_rsp),
        .ent_valid (ent_valid),
        .ent_code  (ent_code)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_slot
            assign grp_req[g][i] = ent_valid[i] && r_q.pend[i] && (ent_code[i] == 2'(g));
        end
        sqo_low_pick #(.N(NUM_PAIRS), .IW(IDX_W)) u_pick (
            .req   (grp_req[g]),
            .found (grp_found[g]),
            .idx   (grp_idx[g])
        );
    end

    assign sel_idx = grp_idx[emit_grp];

    always_comb begin
        r_d      = r_q;
        r_d.ov   = 1'b0;
        r_d.olast = 1'b0;
        emit     = 1'b0;
        emit_grp = GRP_00;

        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start && !busy_w) begin
                    r_d.st        = ST_CLASSIFY;
                    r_d.scan      = '0;
                    r_d.pend      = ent_valid;
                    r_d.total     = '0;
                    r_d.emitted   = '0;
                    r_d.c_orig    = '0;
                    r_d.c_new     = '0;
                    r_d.have_prev = 1'b0;
                end
            end
            ST_CLASSIFY: begin
                if (ent_valid[r_q.scan]) begin
                    r_d.total = r_q.total + 1'b1;
                    if (r_q.have_prev && (ent_code[r_q.scan][1] != r_q.prev_msb))
                        r_d.c_orig = r_q.c_orig + 1'b1;
                    r_d.have_prev = 1'b1;
                    r_d.prev_msb  = ent_code[r_q.scan][0];
                end
                if (int'(r_q.scan) == NUM_PAIRS - 1) begin
                    r_d.st        = ST_EMIT00;
                    r_d.have_prev = 1'b0;
                end else begin
                    r_d.scan = r_q.scan + 1'b1;
                end
            end
            ST_EMIT00: begin
                if (grp_found[GRP_00]) begin
                    emit = 1'b1; emit_grp = GRP_00;
                end else begin
                    r_d.st = ST_EMIT01_ONE;
                end
            end
            ST_EMIT01_ONE: begin
                r_d.st = ST_EMIT11;
                if (grp_found[GRP_01]) begin
                    emit = 1'b1; emit_grp = GRP_01;
                end
            end
            ST_EMIT11: begin
                if (grp_found[GRP_11]) begin
                    emit = 1'b1; emit_grp = GRP_11;
                end else begin
                    r_d.st = ST_ALT10;
                end
            end
            ST_ALT10: begin
                if (grp_found[GRP_10]) begin
                    emit = 1'b1; emit_grp = GRP_10;
                    r_d.st = ST_ALT01;
                end else if (grp_found[GRP_01]) begin
                    r_d.st = ST_DRAIN; r_d.drain_grp = GRP_01;
                end else begin
                    r_d.st = ST_DONE;
                end
            end
            ST_ALT01: begin
                if (grp_found[GRP_01]) begin
                    emit = 1'b1; emit_grp = GRP_01;
                    r_d.st = ST_ALT10;
                end else if (grp_found[GRP_10]) begin
                    r_d.st = ST_DRAIN; r_d.drain_grp = GRP_10;
                end else begin
                    r_d.st = ST_DONE;
                end
            end
            ST_DRAIN: begin
                if (grp_found[r_q.drain_grp]) begin
                    emit = 1'b1; emit_grp = r_q.drain_grp;
                end else begin
                    r_d.st = ST_DONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (emit) begin
            r_d.ov            = 1'b1;
            r_d.oidx          = sel_idx;
            r_d.pend[sel_idx] = 1'b0;
            r_d.olast         = (r_q.emitted + 1'b1 == r_q.total);
            r_d.emitted       = r_q.emitted + 1'b1;
            if (r_q.have_prev && (ent_code[sel_idx][1] != r_q.prev_msb))
                r_d.c_new = r_q.c_new + 1'b1;
            r_d.have_prev = 1'b1;
            r_d.prev_msb  = ent_code[sel_idx][0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign seq_valid  = r_q.ov;
    assign seq_idx    = r_q.oidx;
    assign seq_last   = r_q.olast;
    assign busy       = busy_w;
    assign clash_orig = r_q.c_orig;
    assign clash_new  = r_q.c_new;

    // R6: an emitted index always names a stored slot
    p_emit_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_valid |-> ent_valid[seq_idx]);

    // R6: the last flag only travels with a valid index
    p_last_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_last |-> seq_valid);

    // R6: the same index never appears on two consecutive beats
    p_no_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_valid |=> !(seq_valid && seq_idx == $past(seq_idx)));

    // R8: with no run and no start, both counts hold
    p_counts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(clash_new) && $stable(clash_orig)));

    // R8: the reordered count grows by at most one per emitted beat
    p_new_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (clash_new == $past(clash_new) || clash_new == $past(clash_new) + 1'b1));

endmodule

// File: tb/scan_order_seq_tb_top.sv
module scan_order_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P  = 8;
    localparam int W  = 4;
    localparam int IW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [W-1:0]  ld_vec = '0;
    logic [W-1:0]  ld_rsp = '0;
    logic          start = 1'b0;
    logic          seq_valid, seq_last, busy;
    logic [IW-1:0] seq_idx;
    logic [CW-1:0] clash_orig, clash_new;

    scan_order_seq #(.NUM_PAIRS(P), .VEC_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_vec(ld_vec), .ld_rsp(ld_rsp), .start(start),
        .seq_valid(seq_valid), .seq_idx(seq_idx), .seq_last(seq_last),
        .busy(busy), .clash_orig(clash_orig), .clash_new(clash_new)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int         n_tests = 0;
    int         n_fail  = 0;
    logic [W-1:0] m_vec [P];
    logic [W-1:0] m_rsp [P];
    bit         m_val [P];
    int         exp_q[$];
    string      tag_q[$];
    int         exp_orig, exp_new;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int grp_of(input int i);
        return {m_vec[i][0], m_rsp[i][W-1]};
    endfunction

    function automatic int count_clash(input int order[$]);
        int c = 0;
        for (int k = 1; k < order.size(); k++)
            if (m_vec[order[k]][0] != m_rsp[order[k-1]][W-1]) c++;
        return c;
    endfunction

    function automatic void build_model();
        int g[4][$];
        int asc[$];
        bit turn10;
        exp_q.delete();
        tag_q.delete();
        for (int i = 0; i < P; i++)
            if (m_val[i]) begin
                g[grp_of(i)].push_back(i);
                asc.push_back(i);
            end
        while (g[0].size() > 0) begin exp_q.push_back(g[0].pop_front()); tag_q.push_back("R1"); end
        if (g[1].size() > 0) begin exp_q.push_back(g[1].pop_front()); tag_q.push_back("R2"); end
        while (g[3].size() > 0) begin exp_q.push_back(g[3].pop_front()); tag_q.push_back("R3"); end
        turn10 = 1'b1;
        while (g[2].size() > 0 || g[1].size() > 0) begin
            if (turn10) begin
                if (g[2].size() > 0) begin exp_q.push_back(g[2].pop_front()); tag_q.push_back("R4"); end
                else begin exp_q.push_back(g[1].pop_front()); tag_q.push_back("R5"); end
            end else begin
                if (g[1].size() > 0) begin exp_q.push_back(g[1].pop_front()); tag_q.push_back("R4"); end
                else begin exp_q.push_back(g[2].pop_front()); tag_q.push_back("R5"); end
            end
            turn10 = !turn10;
        end
        exp_orig = count_clash(asc);
        exp_new  = count_clash(exp_q);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; ld_en = 1'b0; start = 1'b0;
        for (int i = 0; i < P; i++) m_val[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_load(input int idx, input logic [W-1:0] v, input logic [W-1:0] r);
        ld_en = 1'b1; ld_idx = IW'(idx); ld_vec = v; ld_rsp = r;
        @(negedge clk);
        ld_en = 1'b0;
        m_vec[idx] = v; m_rsp[idx] = r; m_val[idx] = 1'b1;
    endtask

    task automatic run_seq(input bit poke);
        int cyc = 0;
        int e;
        string t;
        build_model();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            @(negedge clk);
            if (seq_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "extra index", int'(seq_idx), -1);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(int'(seq_idx) == e, t, "emitted index", int'(seq_idx), e);
                    chk(seq_last == (exp_q.size() == 0), "R6", "last flag",
                        int'(seq_last), int'(exp_q.size() == 0));
                end
            end else begin
                chk(seq_last == 1'b0, "R6", "last without valid", int'(seq_last), 0);
            end
            if (poke && cyc == 2) begin
                ld_en = 1'b1; ld_idx = '0; ld_vec = ~m_vec[0]; ld_rsp = ~m_rsp[0];
                start = 1'b1;
            end
            if (poke && cyc == 3) begin
                ld_en = 1'b0; start = 1'b0;
            end
            if (!busy) break;
            cyc++;
        end
        ld_en = 1'b0; start = 1'b0;
        chk(exp_q.size() == 0, "R6", "missing indices", exp_q.size(), 0);
        chk(int'(clash_orig) == exp_orig, "R7", "original clashes", int'(clash_orig), exp_orig);
        chk(int'(clash_new) == exp_new, "R8", "reordered clashes", int'(clash_new), exp_new);
        repeat (2) @(negedge clk);
        chk(!seq_valid && !busy, "R6", "quiet after run", int'(seq_valid), 0);
        chk(int'(clash_new) == exp_new, "R8", "count held", int'(clash_new), exp_new);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        chk(!seq_valid && !busy, "R10", "valid/busy after reset", int'(seq_valid || busy), 0);
        chk(clash_orig == 0 && clash_new == 0, "R10", "counts after reset",
            int'(clash_orig) + int'(clash_new), 0);
        // R6: empty store emits nothing
        run_seq(1'b0);

        // worked seven-pair set
        do_load(0, 4'b0101, 4'b1001);
        do_load(1, 4'b1100, 4'b1000);
        do_load(2, 4'b0110, 4'b0011);
        do_load(3, 4'b1101, 4'b0000);
        do_load(4, 4'b0000, 4'b1001);
        do_load(5, 4'b1101, 4'b0101);
        do_load(6, 4'b0100, 4'b0001);
        run_seq(1'b0);
        chk(clash_orig == 3, "R7", "worked set original", int'(clash_orig), 3);
        chk(clash_new == 0, "R8", "worked set reordered", int'(clash_new), 0);

        // R11: overwrite index 3 (group 10 -> group 01)
        do_load(3, 4'b0100, 4'b1000);
        run_seq(1'b0);

        // R9: loads and start during a run, then rerun on unchanged data
        run_seq(1'b1);
        run_seq(1'b0);

        // sets with biased group populations
        for (int c = 0; c < 40; c++) begin
            do_reset();
            for (int i = 0; i < P; i++) begin
                logic [W-1:0] v, r;
                v = W'($urandom);
                r = W'($urandom);
                case (c % 5)
                    1: begin v[0] = 1'b1; r[W-1] = 1'b0; end
                    2: begin v[0] = 1'b0; r[W-1] = 1'b1; end
                    3: if (v[0] != r[W-1]) v[0] = r[W-1];
                    4: if (v[0] == 1'b0 && r[W-1] == 1'b1) r[W-1] = 1'b0;
                    default: ;
                endcase
                if (($urandom % 4) != 0 || c % 5 != 0) do_load(i, v, r);
            end
            run_seq(1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule